// File: doc/BRIEF.md
# Memory-or-Lookup Logic Cell

This block is one tile of a reconfigurable array. It is built around a small synchronous storage array that can play three roles. It can act as ordinary memory. It can act as a lookup table that turns two input nibbles into an arbitrary 8-bit function. It can also step aside and pass its nibble inputs straight to its nibble outputs. Two internal configuration registers pick the role and the wiring: a mode register and a channel register. Both are written through a dedicated configuration strobe, so the function of a cell can be swapped while the surrounding array keeps running. A write to one cell's registers touches nothing else.

Neighbouring cells reach this one through a set of 4-bit input ports and 4-bit output ports. The channel register decides which input port supplies each nibble of the storage address and of the write data. In the memory and logic roles, output ports 0 and 1 carry the word most recently read. Ports 2 and 3 come from a bank of eight nibble registers. That bank captures read results into one slot pair and shows a slot pair that can be chosen separately. A cell can therefore forward a fresh result and hold older ones at the same time.

Top module: `sram_logic_cell`

## Requirements
- R1: While `rst_n` is low, the mode and channel registers, the read register and all eight bank slots are cleared. With the mode code at 0, every output port k equals input port k in the same cycle.
- R2: On a clock edge with `cfg_we` high, `cfg_data` loads the mode register when `cfg_sel` is 0 and the channel register when `cfg_sel` is 1. The loaded value governs operation from the next edge on. Without `cfg_we`, both registers keep their value.
- R3: Mode register bits [3:0] hold the role code. Codes 1 and 2 select the memory group, codes 3, 4 and 5 select the logic group, and every other code (0, 6 to 15) selects through-access.
- R4: The channel register holds four 2-bit input port numbers. Bits [1:0] pick the address high nibble, [3:2] the address low nibble, [5:4] the write-data high nibble and [7:6] the write-data low nibble.
- R5: In the memory or logic group, an edge with `ce` and `we` both high stores the selected data word at the selected address.
- R6: In the memory group, an edge with `ce` high and `we` low loads the addressed word into the read register. Port 0 shows bits [7:4] of that register and port 1 shows bits [3:0], after that edge. With `ce` low, the read register holds.
- R7: In the logic group, every edge without a write loads the word at the address formed from the selected nibbles into the read register, whatever `ce` is.
- R8: In through-access, `ce` with `we` writes nothing. The stored word stays as it was and can be read back later.
- R9: Mode bits [5:4] name the capture pair p and bits [7:6] the view pair q. Every read stores the high nibble of the word in bank slot 2p and the low nibble in slot 2p+1. Outside through-access, port 2 shows slot 2q and port 3 shows slot 2q+1, and the bank holds when there is no read.
- R10: A write in the logic group rewrites a table entry, and no evaluation happens on that edge. Ports 0 and 1 keep their previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Set/reset; low forces the reset state and through-access |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | Configuration target: 0 mode register, 1 channel register |
| cfg_data | input | 8 | Configuration value |
| ce | input | 1 | Storage enable |
| we | input | 1 | Storage write select (with `ce`) |
| in_nib | input | N_PORT*4 | Input nibble ports, port k at bits [4k+3:4k] |
| out_nib | output | N_PORT*4 | Output nibble ports, port k at bits [4k+3:4k] |

## Verification
The bench builds the cell with its default parameters: four nibble ports, an 8-bit address giving 256 words of 8 bits, and an eight-slot output bank. With these values the whole storage array can be filled and read back, so every lookup address the logic roles can form gives a known result. With four ports, every channel permutation and all four bank pairs can be reached, including the case where the capture pair and the view pair differ.

// File: rtl/slc_pkg.sv
package slc_pkg;

    // Role groups decoded from the 4-bit role code.
    typedef enum logic [1:0] {
        GRP_THRU  = 2'd0,
        GRP_MEM   = 2'd1,
        GRP_LOGIC = 2'd2
    } grp_e;

    localparam int CFG_W    = 8;
    localparam int CODE_W   = 4;

    function automatic grp_e decode_group(input logic [CODE_W-1:0] code);
        grp_e g;
        case (code)
            4'd1, 4'd2:       g = GRP_MEM;
            4'd3, 4'd4, 4'd5: g = GRP_LOGIC;
            default:          g = GRP_THRU;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/slc_cfg.sv
module slc_cfg
    import slc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [CFG_W-1:0] cfg_data,
    output logic [CFG_W-1:0] mode_q,
    output logic [CFG_W-1:0] chan_q,
    output grp_e             grp
);

    typedef struct packed {
        logic [CFG_W-1:0] mode;
        logic [CFG_W-1:0] chan;
    } cfg_t;

    cfg_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cfg_we) begin
            if (cfg_sel) s_d.chan = cfg_data;
            else         s_d.mode = cfg_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign mode_q = s_q.mode;
    assign chan_q = s_q.chan;
    assign grp    = decode_group(s_q.mode[CODE_W-1:0]);

endmodule

// File: rtl/slc_portsel.sv
module slc_portsel #(
    parameter int NIB_W  = 4,
    parameter int N_PORT = 4,
    localparam int SEL_W = $clog2(N_PORT),
    localparam int N_LANE = 4
) (
    input  logic [N_PORT*NIB_W-1:0] in_nib,
    input  logic [N_LANE*SEL_W-1:0] chan,
    output logic [2*NIB_W-1:0]      addr,
    output logic [2*NIB_W-1:0]      wdata
);

    logic [N_LANE-1:0][NIB_W-1:0] lane;

    for (genvar f = 0; f < N_LANE; f++) begin : g_lane
        always_comb begin
            lane[f] = '0;
            for (int p = 0; p < N_PORT; p++) begin
                if (chan[f*SEL_W +: SEL_W] == SEL_W'(p))
                    lane[f] = in_nib[p*NIB_W +: NIB_W];
            end
        end
    end

    assign addr  = {lane[0], lane[1]};
    assign wdata = {lane[2], lane[3]};

endmodule

// File: rtl/slc_store.sv
module slc_store #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] peek,
    output logic [DATA_W-1:0] rdata_q
);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rdata_d;

    assign peek = mem[addr];

    always_comb begin
        rdata_d = rdata_q;
        if (rd_en) rdata_d = peek;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

endmodule

// File: rtl/sram_logic_cell.sv
module sram_logic_cell
    import slc_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int N_PORT = 4,
    parameter int NREG   = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic                    cfg_sel,
    input  logic [CFG_W-1:0]        cfg_data,
    input  logic                    ce,
    input  logic                    we,
    input  logic [N_PORT*NIB_W-1:0] in_nib,
    output logic [N_PORT*NIB_W-1:0] out_nib
);

    localparam int WORD_W = 2 * NIB_W;
    localparam int SEL_W  = $clog2(N_PORT);
    localparam int SLOT_W = $clog2(NREG);
    localparam int PAIR_W = SLOT_W - 1;
    localparam int CAP_LSB  = CODE_W;
    localparam int VIEW_LSB = CODE_W + PAIR_W;

    logic [CFG_W-1:0]  mode_q, chan_q;
    grp_e              grp;
    logic [WORD_W-1:0] addr, wdata, peek, rdata_q;
    logic              wr_en, rd_en;
    logic [PAIR_W-1:0] cap_pair, view_pair;

    typedef struct packed {
        logic [NREG-1:0][NIB_W-1:0] bank;
    } st_t;

    st_t s_d, s_q;
    logic [NREG*NIB_W-1:0] bank_flat;

    slc_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .mode_q   (mode_q),
        .chan_q   (chan_q),
        .grp      (grp)
    );

    slc_portsel #(.NIB_W(NIB_W), .N_PORT(N_PORT)) u_sel (
        .in_nib (in_nib),
        .chan   (chan_q[4*SEL_W-1:0]),
        .addr   (addr),
        .wdata  (wdata)
    );

    slc_store #(.ADDR_W(WORD_W), .DATA_W(WORD_W)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .peek    (peek),
        .rdata_q (rdata_q)
    );

    assign cap_pair  = mode_q[CAP_LSB  +: PAIR_W];
    assign view_pair = mode_q[VIEW_LSB +: PAIR_W];

    always_comb begin
        wr_en = ce && we && (grp != GRP_THRU);
        rd_en = !(ce && we) && (((grp == GRP_MEM) && ce) || (grp == GRP_LOGIC));

        s_d = s_q;
        if (rd_en) begin
            s_d.bank[{cap_pair, 1'b0}] = peek[WORD_W-1:NIB_W];
            s_d.bank[{cap_pair, 1'b1}] = peek[NIB_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign bank_flat = s_q.bank;

    always_comb begin
        if (grp == GRP_THRU) begin
            out_nib = in_nib;
        end else begin
            out_nib = '0;
            out_nib[0*NIB_W +: NIB_W] = rdata_q[WORD_W-1:NIB_W];
            out_nib[1*NIB_W +: NIB_W] = rdata_q[NIB_W-1:0];
            out_nib[2*NIB_W +: NIB_W] = s_q.bank[{view_pair, 1'b0}];
            out_nib[3*NIB_W +: NIB_W] = s_q.bank[{view_pair, 1'b1}];
        end
    end

endmodule

// File: rtl/slc_checker.sv
module slc_checker
    import slc_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int N_PORT = 4,
    parameter int NREG   = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cfg_we,
    input logic                    ce,
    input logic                    we,
    input logic [N_PORT*NIB_W-1:0] in_nib,
    input logic [N_PORT*NIB_W-1:0] out_nib,
    input logic [CFG_W-1:0]        mode_q,
    input logic [CFG_W-1:0]        chan_q,
    input grp_e                    grp,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [2*NIB_W-1:0]      peek,
    input logic [2*NIB_W-1:0]      rdata_q,
    input logic [NREG*NIB_W-1:0]   bank_flat
);

    assert_thru_route_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == GRP_THRU) |-> (out_nib == in_nib));

    assert_cfg_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> ($stable(mode_q) && $stable(chan_q)));

    assert_mem_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp == GRP_MEM) && !ce) |=> $stable(rdata_q));

    assert_logic_eval_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp == GRP_LOGIC) && !(ce && we)) |=> (rdata_q == $past(peek)));

    assert_thru_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (grp == GRP_THRU) |-> !wr_en);

    assert_bank_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(bank_flat));

    assert_lut_write_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((grp == GRP_LOGIC) && ce && we) |=> $stable(rdata_q));

endmodule

bind sram_logic_cell slc_checker #(.NIB_W(NIB_W), .N_PORT(N_PORT), .NREG(NREG)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .ce        (ce),
    .we        (we),
    .in_nib    (in_nib),
    .out_nib   (out_nib),
    .mode_q    (mode_q),
    .chan_q    (chan_q),
    .grp       (grp),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .peek      (peek),
    .rdata_q   (rdata_q),
    .bank_flat (bank_flat)
);

// File: tb/sram_logic_cell_test.sv
module sram_logic_cell_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [7:0]  cfg_data = '0;
    logic        ce = 1'b0;
    logic        we = 1'b0;
    logic [15:0] in_nib = 16'h1234;
    logic [15:0] out_nib;

    always #2.5 clk = ~clk;

    sram_logic_cell uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_sel  (cfg_sel),
        .cfg_data (cfg_data),
        .ce       (ce),
        .we       (we),
        .in_nib   (in_nib),
        .out_nib  (out_nib)
    );

    // Behavioural reference state
    logic [7:0] m_mem [256];
    logic [7:0] m_mode, m_chan, m_rd;
    logic [3:0] m_bank [8];

    int    n_total = 0;
    int    n_fail  = 0;
    int    cycles  = 0;
    bit    done    = 0;
    string cur_req = "R1";

    function automatic int grp_of(input logic [3:0] c);
        if (c == 4'd1 || c == 4'd2) return 1;
        if (c == 4'd3 || c == 4'd4 || c == 4'd5) return 2;
        return 0;
    endfunction

    function automatic logic [3:0] pin(input int k);
        return in_nib[k*4 +: 4];
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = '0; m_chan = '0; m_rd = '0;
            for (int i = 0; i < 8; i++) m_bank[i] = '0;
        end else begin
            int g;
            logic [7:0] a, d;
            bit wr, rd;
            g  = grp_of(m_mode[3:0]);
            a  = {pin(int'(m_chan[1:0])), pin(int'(m_chan[3:2]))};
            d  = {pin(int'(m_chan[5:4])), pin(int'(m_chan[7:6]))};
            wr = ce && we && g != 0;
            rd = !(ce && we) && ((g == 1 && ce) || g == 2);
            if (rd) begin
                m_rd = m_mem[a];
                m_bank[2*int'(m_mode[5:4])]   = m_mem[a][7:4];
                m_bank[2*int'(m_mode[5:4])+1] = m_mem[a][3:0];
            end
            if (wr) m_mem[a] = d;
            if (cfg_we) begin
                if (cfg_sel) m_chan = cfg_data;
                else         m_mode = cfg_data;
            end
        end
    end

    function automatic logic [15:0] exp_out();
        int q;
        if (grp_of(m_mode[3:0]) == 0) return in_nib;
        q = int'(m_mode[7:6]);
        return {m_bank[2*q+1], m_bank[2*q], m_rd[3:0], m_rd[7:4]};
    endfunction

    task automatic step();
        logic [15:0] e;
        @(negedge clk);
        e = exp_out();
        n_total++;
        if (out_nib !== e) begin
            n_fail++;
            $display("FAIL %s: out_nib=%h expected %h at cycle %0d", cur_req, out_nib, e, cycles);
        end
    endtask

    task automatic cyc(input bit c, input bit w, input logic [15:0] v);
        ce = c; we = w; in_nib = v;
        step();
    endtask

    task automatic cfg(input bit sel, input logic [7:0] v);
        cfg_we = 1'b1; cfg_sel = sel; cfg_data = v; ce = 1'b0; we = 1'b0;
        step();
        cfg_we = 1'b0;
    endtask

    // Pack for channel 8'hE4: port0 addr hi, port1 addr lo, port2 data hi, port3 data lo
    function automatic logic [15:0] pk(input logic [7:0] a, input logic [7:0] d);
        return {d[3:0], d[7:4], a[3:0], a[7:4]};
    endfunction

    function automatic logic [7:0] fill_val(input int a);
        return 8'((a * 37 + 11) ^ (a >> 3));
    endfunction

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fail++; n_total++;
            $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 150000", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        // R1: reset state and through routing
        cur_req = "R1";
        for (int i = 0; i < 3; i++) cyc(1'b1, 1'b1, 16'(i * 16'h1357 + 16'h0f0f));
        rst_n = 1'b1;
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 16'($urandom));

        // R4: channel map, then R2 mode load
        cur_req = "R4";
        cfg(1'b1, 8'hE4);
        cur_req = "R2";
        cfg(1'b0, 8'h01);

        // R5: fill the whole store in memory mode
        cur_req = "R5";
        for (int a = 0; a < 256; a++) cyc(1'b1, 1'b1, pk(8'(a), fill_val(a)));

        // R6: reads and holds
        cur_req = "R6";
        for (int i = 0; i < 40; i++)
            cyc(1'(i % 3 != 0), 1'b0, pk(8'($urandom), 8'($urandom)));

        // R2: a config write with a read on the same edge acts in the old mode
        cur_req = "R2";
        ce = 1'b1; we = 1'b0; in_nib = pk(8'h42, 8'h00);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_data = 8'h04;
        step();
        cfg_we = 1'b0;
        cyc(1'b0, 1'b0, pk(8'h43, 8'h00));

        // R4: reversed channel permutation, external memory code
        cur_req = "R4";
        cfg(1'b1, 8'h1B);
        cfg(1'b0, 8'h02);
        for (int i = 0; i < 30; i++) cyc(1'b1, 1'(i % 4 == 0), 16'($urandom));
        cfg(1'b1, 8'hE4);

        // R8: writes in through-access are blocked
        cur_req = "R8";
        cfg(1'b0, 8'h00);
        cyc(1'b1, 1'b1, pk(8'h10, 8'hA5));
        cyc(1'b1, 1'b1, pk(8'h11, 8'h5A));
        // R3: codes 6 and 15 are through-access
        cur_req = "R3";
        cfg(1'b0, 8'h06);
        cyc(1'b1, 1'b1, pk(8'h12, 8'hC3));
        cfg(1'b0, 8'h0F);
        cyc(1'b1, 1'b1, pk(8'h13, 8'h3C));
        cur_req = "R8";
        cfg(1'b0, 8'h01);
        for (int a = 16; a < 20; a++) cyc(1'b1, 1'b0, pk(8'(a), 8'h00));

        // R7: logic codes evaluate every edge regardless of ce
        cur_req = "R7";
        for (int code = 3; code <= 5; code++) begin
            cfg(1'b0, 8'(code));
            for (int i = 0; i < 20; i++) cyc(1'(i % 2), 1'b0, 16'($urandom));
        end

        // R10: table rewrite in logic mode
        cur_req = "R10";
        cyc(1'b1, 1'b1, pk(8'h77, 8'h9E));
        cyc(1'b1, 1'b1, pk(8'h78, 8'h61));
        cyc(1'b0, 1'b0, pk(8'h77, 8'h00));
        cyc(1'b0, 1'b0, pk(8'h78, 8'h00));

        // R9: capture pair and view pair selection
        cur_req = "R9";
        for (int p = 0; p < 4; p++) begin
            cfg(1'b0, {2'(p), 2'(p), 4'd1});
            cyc(1'b1, 1'b0, pk(8'(p * 50 + 3), 8'h00));
            cyc(1'b0, 1'b0, 16'h0);
        end
        for (int q = 0; q < 4; q++) begin
            cfg(1'b0, {2'(q), 2'd1, 4'd4});
            for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, 16'($urandom));
        end
        cfg(1'b0, 8'hC1);
        for (int i = 0; i < 6; i++) cyc(1'b0, 1'b0, 16'($urandom));

        // R1: reset mid-run clears mode and bank
        cur_req = "R1";
        rst_n = 1'b0;
        cyc(1'b0, 1'b0, 16'hBEEF);
        cyc(1'b0, 1'b0, 16'h0123);
        rst_n = 1'b1;
        cfg(1'b0, 8'hE4);
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 16'($urandom));

        done = 1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule